// File: doc/BRIEF.md
# Two-Path FFT Block Exchanger

This block sits between stages of a two-lane feed-forward FFT pipeline. Each lane carries one complex sample per valid cycle. At the input the upper lane carries blocks A, B, A, B, ... and the lower lane carries blocks C, D, C, D, .... Each block holds `BLK_LEN` samples. The next butterfly stage needs the samples that belong together to arrive on the same cycle. The exchanger therefore swaps the second upper block with the first lower block. The result is that A leaves beside B, then C leaves beside D.

The structure is a delay line of `BLK_LEN` words on each lane, two 2:1 steering multiplexers and an output register stage. The multiplexer select is a phase bit. It comes from a sample counter that advances only on valid cycles, so the routing follows a fixed schedule and never depends on the data. Cycles without a valid input freeze the whole block. Gaps in the stream therefore do not disturb the pairing.

The samples are numbered by valid-input index n, counted from reset and starting at 0. The phase of sample n is floor(n / `BLK_LEN`) mod 2. `BLK_LEN` must be a power of two. Each output word is packed as {real, imaginary}.

Top module: `fft_pair_shuffler`

## Requirements
- R1: While `rstN` is low, and at the first clock after it is released with no valid input, `outValid` is 0 and all four output data fields are 0.
- R2: The first `BLK_LEN` valid inputs after reset produce no output: `outValid` stays 0 in the clock after each of them.
- R3: For a valid input with index n ≥ `BLK_LEN` and phase 1, the output pair carries upper-lane sample n−`BLK_LEN` on the upper output and upper-lane sample n on the lower output (block A beside block B).
- R4: For a valid input with index n ≥ `BLK_LEN` and phase 0, the output pair carries lower-lane sample n−2·`BLK_LEN` on the upper output and lower-lane sample n−`BLK_LEN` on the lower output (block C beside block D). When n < 2·`BLK_LEN` the upper output is 0.
- R5: The outputs are registered. Every valid input with index n ≥ `BLK_LEN` raises `outValid` for exactly the following clock, and `outValid` is never 1 unless `inValid` was 1 one clock earlier.
- R6: A cycle with `inValid` low has no effect on the block. In the next clock `outValid` is 0 and all output data fields hold their previous values. The pairing of later samples also stays unchanged.
- R7: The phase toggles after every `BLK_LEN` valid inputs and never on an invalid cycle. This holds for `BLK_LEN` of 1, 2 and 4 alike.
- R8: The real and imaginary parts of a sample always travel together and land in the same output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A sample pair is present on both input lanes |
| inUpRe | input | DATA_W | Upper lane input, real part |
| inUpIm | input | DATA_W | Upper lane input, imaginary part |
| inLoRe | input | DATA_W | Lower lane input, real part |
| inLoIm | input | DATA_W | Lower lane input, imaginary part |
| outValid | output | 1 | Output pair is valid this cycle |
| outUpRe | output | DATA_W | Upper lane output, real part |
| outUpIm | output | DATA_W | Upper lane output, imaginary part |
| outLoRe | output | DATA_W | Lower lane output, real part |
| outLoIm | output | DATA_W | Lower lane output, imaginary part |

## Verification
Every input sample carries a unique value that encodes its lane and index. A phase bit that is off by one sample, or that advances on an idle cycle, therefore shows up as a wrong index at the first output of the next block, within `BLK_LEN` valid cycles. A delay line that is one stage too short or too long shifts every sample that crosses it, so the first mismatch appears in the output that directly follows the fill phase. Three instances with block lengths 4, 2 and 1 receive the same stimulus, including runs with gaps in the valid stream, so that each instance is checked against its own schedule.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic advance;  // a valid sample pair is present: shift both delay lines
    logic swap;     // phase bit: 1 = second half of the 2*L period
    logic emit;     // capture an output pair this cycle
  } shufStrobe_t;

endpackage

// File: rtl/shuf_ctrl.sv
module shuf_ctrl
  import shuf_pkg::*;
#(
  parameter int BLK_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output shufStrobe_t strobe
);

  localparam int CNT_W = $clog2(2 * BLK_LEN);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(BLK_LEN - 1);

  logic [CNT_W-1:0] sampleCnt;
  logic             filled;

  // The counter wraps at 2*L, so its top bit is the bit of weight L.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
      filled    <= 1'b0;
    end else if (inValid) begin
      sampleCnt <= sampleCnt + 1'b1;
      if (sampleCnt == FILL_LAST) begin
        filled <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.advance = inValid;
    strobe.swap    = sampleCnt[CNT_W-1];
    strobe.emit    = inValid & filled;
  end

endmodule

// File: rtl/shuf_delay.sv
module shuf_delay #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  logic [WORD_W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        stage[i] <= '0;
      end
    end else if (en) begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/shuf_datapath.sv
module shuf_datapath
  import shuf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  shufStrobe_t         strobe,
  input  logic [2*DATA_W-1:0] inUp,
  input  logic [2*DATA_W-1:0] inLo,
  output logic                outValid,
  output logic [2*DATA_W-1:0] outUp,
  output logic [2*DATA_W-1:0] outLo
);

  localparam int WORD_W = 2 * DATA_W;

  logic [WORD_W-1:0] loDelayed;
  logic [WORD_W-1:0] upDelayIn;
  logic [WORD_W-1:0] upDelayed;

  // The lower lane always waits L samples.
  shuf_delay #(.WORD_W(WORD_W), .DEPTH(BLK_LEN)) loLine (
    .clk (clk),
    .rstN(rstN),
    .en  (strobe.advance),
    .din (inLo),
    .dout(loDelayed)
  );

  // Entry multiplexer: in phase 0 the upper sample is stored, in phase 1
  // the delayed lower sample takes its place (block C moves up).
  assign upDelayIn = strobe.swap ? loDelayed : inUp;

  shuf_delay #(.WORD_W(WORD_W), .DEPTH(BLK_LEN)) upLine (
    .clk (clk),
    .rstN(rstN),
    .en  (strobe.advance),
    .din (upDelayIn),
    .dout(upDelayed)
  );

  // Exit multiplexer and output register stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outUp    <= '0;
      outLo    <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outUp <= upDelayed;
        outLo <= strobe.swap ? inUp : loDelayed;
      end
    end
  end

endmodule

// File: rtl/fft_pair_shuffler.sv
module fft_pair_shuffler
  import shuf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inUpRe,
  input  logic [DATA_W-1:0] inUpIm,
  input  logic [DATA_W-1:0] inLoRe,
  input  logic [DATA_W-1:0] inLoIm,
  output logic              outValid,
  output logic [DATA_W-1:0] outUpRe,
  output logic [DATA_W-1:0] outUpIm,
  output logic [DATA_W-1:0] outLoRe,
  output logic [DATA_W-1:0] outLoIm
);

  localparam int WORD_W = 2 * DATA_W;

  shufStrobe_t       strobe;
  logic [WORD_W-1:0] outUpWord;
  logic [WORD_W-1:0] outLoWord;

  shuf_ctrl #(.BLK_LEN(BLK_LEN)) sequencer (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobe (strobe)
  );

  shuf_datapath #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN)) lanes (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inUp    ({inUpRe, inUpIm}),
    .inLo    ({inLoRe, inLoIm}),
    .outValid(outValid),
    .outUp   (outUpWord),
    .outLo   (outLoWord)
  );

  assign {outUpRe, outUpIm} = outUpWord;
  assign {outLoRe, outLoIm} = outLoWord;

endmodule

// File: rtl/shuf_checker.sv
module shuf_checker #(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inUpRe,
  input logic [DATA_W-1:0] inUpIm,
  input logic              outValid,
  input logic [DATA_W-1:0] outUpRe,
  input logic [DATA_W-1:0] outUpIm,
  input logic [DATA_W-1:0] outLoRe,
  input logic [DATA_W-1:0] outLoIm,
  input logic              swapPhase
);

  localparam int SEEN_W = $clog2(BLK_LEN + 1);
  localparam logic [SEEN_W-1:0] SEEN_FULL = SEEN_W'(BLK_LEN);

  // Saturating count of valid inputs since reset.
  logic [SEEN_W-1:0] seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen <= '0;
    end else if (inValid && seen != SEEN_FULL) begin
      seen <= seen + 1'b1;
    end
  end

  // R2: no output while the delay lines are filling
  a_r2_quiet_fill: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && seen < SEEN_FULL) |=> !outValid);

  // R5: every valid input after the fill gives exactly one output pair
  a_r5_emit_after_fill: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && seen == SEEN_FULL) |=> outValid);

  // R5: no output pair without a valid input one clock earlier
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R6: an idle cycle leaves the outputs frozen
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outUpRe) && $stable(outUpIm)
                  && $stable(outLoRe) && $stable(outLoIm)));

  // R7: the phase bit never moves on an idle cycle
  a_r7_phase_steady: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(swapPhase));

  // R3: in phase 1 the current upper sample leaves on the lower output
  a_r3_upper_to_lower: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && seen == SEEN_FULL && swapPhase)
      |=> (outLoRe == $past(inUpRe) && outLoIm == $past(inUpIm)));

endmodule

bind fft_pair_shuffler shuf_checker #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN)) checks (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inUpRe   (inUpRe),
  .inUpIm   (inUpIm),
  .outValid (outValid),
  .outUpRe  (outUpRe),
  .outUpIm  (outUpIm),
  .outLoRe  (outLoRe),
  .outLoIm  (outLoIm),
  .swapPhase(strobe.swap)
);

// File: tb/fft_pair_shuffler_test.sv
module fft_pair_shuffler_test;

  localparam int DW = 16;
  localparam int NI = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          rstN;
  logic          inValid;
  logic [DW-1:0] inUpRe, inUpIm, inLoRe, inLoIm;

  logic          oV  [NI];
  logic [DW-1:0] oUR [NI];
  logic [DW-1:0] oUI [NI];
  logic [DW-1:0] oLR [NI];
  logic [DW-1:0] oLI [NI];

  int lens [NI] = '{4, 2, 1};

  fft_pair_shuffler #(.DATA_W(DW), .BLK_LEN(4)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inUpRe(inUpRe), .inUpIm(inUpIm), .inLoRe(inLoRe), .inLoIm(inLoIm),
    .outValid(oV[0]), .outUpRe(oUR[0]), .outUpIm(oUI[0]),
    .outLoRe(oLR[0]), .outLoIm(oLI[0]));

  fft_pair_shuffler #(.DATA_W(DW), .BLK_LEN(2)) uut2 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inUpRe(inUpRe), .inUpIm(inUpIm), .inLoRe(inLoRe), .inLoIm(inLoIm),
    .outValid(oV[1]), .outUpRe(oUR[1]), .outUpIm(oUI[1]),
    .outLoRe(oLR[1]), .outLoIm(oLI[1]));

  fft_pair_shuffler #(.DATA_W(DW), .BLK_LEN(1)) uut1 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inUpRe(inUpRe), .inUpIm(inUpIm), .inLoRe(inLoRe), .inLoIm(inLoIm),
    .outValid(oV[2]), .outUpRe(oUR[2]), .outUpIm(oUI[2]),
    .outLoRe(oLR[2]), .outLoIm(oLI[2]));

  // Reference model state: every accepted sample, packed {re, im}.
  logic [31:0] upHist[$];
  logic [31:0] loHist[$];
  logic [31:0] lastUp [NI];
  logic [31:0] lastLo [NI];
  int nValid;
  int checks;
  int fails;
  bit finished;

  task automatic check(string req, int inst, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s L=%0d %s: actual %h expected %h", req, lens[inst], what, act, exp);
    end
  endtask

  task automatic checkBit(string req, int inst, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s L=%0d outValid: actual %b expected %b", req, lens[inst], act, exp);
    end
  endtask

  task automatic checkHeld(int inst);
    check("R6", inst, oUR[inst], lastUp[inst][31:16], "held upper re");
    check("R6", inst, oUI[inst], lastUp[inst][15:0],  "held upper im");
    check("R6", inst, oLR[inst], lastLo[inst][31:16], "held lower re");
    check("R6", inst, oLI[inst], lastLo[inst][15:0],  "held lower im");
  endtask

  // Called at a negedge: drive one cycle, then check at the next negedge.
  task automatic step(bit v, logic [31:0] up, logic [31:0] lo);
    inValid = v;
    {inUpRe, inUpIm} = up;
    {inLoRe, inLoIm} = lo;
    @(negedge clk);
    if (v) begin
      upHist.push_back(up);
      loHist.push_back(lo);
    end
    for (int i = 0; i < NI; i++) begin
      int len;
      len = lens[i];
      if (!v) begin
        checkBit("R6", i, oV[i], 1'b0);
        checkHeld(i);
      end else if (nValid < len) begin
        checkBit("R2", i, oV[i], 1'b0);
        checkHeld(i);
      end else begin
        logic [31:0] expUp, expLo;
        string req;
        // R7: phase counts valid samples only
        if (((nValid / len) % 2) == 1) begin
          req   = "R3";
          expUp = upHist[nValid - len];
          expLo = upHist[nValid];
        end else begin
          req   = "R4";
          expUp = (nValid >= 2 * len) ? loHist[nValid - 2 * len] : 32'h0;
          expLo = loHist[nValid - len];
        end
        checkBit("R5", i, oV[i], 1'b1);
        check(req,  i, oUR[i], expUp[31:16], "upper re");
        check("R8", i, oUI[i], expUp[15:0],  "upper im");
        check(req,  i, oLR[i], expLo[31:16], "lower re");
        check("R8", i, oLI[i], expLo[15:0],  "lower im");
        lastUp[i] = expUp;
        lastLo[i] = expLo;
      end
    end
    if (v) nValid++;
  endtask

  function automatic logic [31:0] mkUp(int n, int seg);
    if (seg == 0) return {16'(16'h1000 + n), 16'(16'h5000 + n)};
    return {16'(-n - 1), 16'(16'h7F00 ^ n)};
  endfunction

  function automatic logic [31:0] mkLo(int n, int seg);
    if (seg == 0) return {16'(16'h3000 + n), 16'(16'h9000 + n)};
    return {16'(16'hC000 - n), 16'(~n)};
  endfunction

  initial begin
    checks = 0; fails = 0; nValid = 0; finished = 0;
    for (int i = 0; i < NI; i++) begin
      lastUp[i] = '0;
      lastLo[i] = '0;
    end
    rstN = 1'b0; inValid = 1'b0;
    inUpRe = '0; inUpIm = '0; inLoRe = '0; inLoIm = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NI; i++) begin
      checkBit("R1", i, oV[i], 1'b0);
      check("R1", i, oUR[i], '0, "reset upper re");
      check("R1", i, oLI[i], '0, "reset lower im");
    end
    rstN = 1'b1;
    step(1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D);  // R1 and R6: idle after reset
    // Unbroken stream
    for (int k = 0; k < 24; k++) step(1'b1, mkUp(nValid, 0), mkLo(nValid, 0));
    // Stream with gaps: R6 and R7
    for (int k = 0; k < 40; k++) begin
      if ((k % 3) == 1 || (k % 7) == 0)
        step(1'b0, 32'hFFFF_0000 ^ k, 32'h0000_FFFF ^ k);
      else
        step(1'b1, mkUp(nValid, 0), mkLo(nValid, 0));
    end
    // Signed and inverted pattern: R8
    for (int k = 0; k < 20; k++) step(1'b1, mkUp(nValid, 1), mkLo(nValid, 1));
    step(1'b0, 32'h0, 32'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #80000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule